// File: doc/BRIEF.md
# DMA Command Strobe Generator

This block produces the four active-low DMA command strobes (I/O read, I/O write, memory read, memory write) for a single transfer cycle at a time. A one-cycle `start` pulse begins a cycle. `dirToMem` selects the strobe pair: an I/O-to-memory transfer drives I/O read with memory write, and a memory-to-I/O transfer drives memory read with I/O write. `is16` selects which wait-state field sets the length of the command.

All timing is counted in a DMA clock, which is derived from the bus clock as a one-cycle enable. The write-command low time is one DMA clock plus a programmable number of wait states, so it is never shorter than two DMA clocks. It can be stretched further by holding `readyIn` low. The memory-read strobe can lag the start of the command by one DMA clock.

A small configuration register is loaded through `cfgWe`/`cfgIn` and resets to all zeros. The settings in force at the moment of `start` govern the whole cycle. When the strobes are released, a one-bus-clock `done` pulse follows in the same cycle.

Top module: `dmaStrobeGen`

## Requirements
- R1: After reset all four strobes are high, `done` is low, and the configuration is 0: one wait state, a DMA clock of two bus clocks, and a delayed memory read.
- R2: With `dirToMem`=1 only the I/O read and memory write strobes go low. With `dirToMem`=0 only the memory read and I/O write strobes go low. The other two stay high throughout.
- R3: For 8-bit transfers (`is16`=0), config bits [3:2] hold a code n. The write strobe then stays low for n+2 DMA clocks when `readyIn` is high.
- R4: For 16-bit transfers (`is16`=1), config bits [5:4] set the write strobe low time with the same n+2 rule.
- R5: Config bit 0 = 0 makes one DMA clock equal two bus clocks. Bit 0 = 1 makes it equal one bus clock. The divider restarts with every transfer.
- R6: Config bit 1 = 0 makes memory read fall one DMA clock after the command starts. Bit 1 = 1 makes it fall in the same cycle as I/O write. Either way it rises with the write strobe.
- R7: While `readyIn` is low at the point where the command would end, the command is held low for another whole DMA clock, and this repeats until `readyIn` is seen high.
- R8: All active strobes rise in the same cycle, and `done` is high for exactly that one bus clock.
- R9: A `start` pulse that arrives while a transfer is active or while `done` is high is ignored.
- R10: The settings are captured at `start`. A config write in the same cycle as `start`, or during the transfer, affects only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgIn | input | 6 | Configuration value: [5:4] 16-bit wait, [3:2] 8-bit wait, [1] memory-read no-delay, [0] fast DMA clock |
| start | input | 1 | One-cycle request to run a transfer cycle |
| dirToMem | input | 1 | 1: I/O to memory, 0: memory to I/O |
| is16 | input | 1 | 1: 16-bit transfer, 0: 8-bit transfer |
| readyIn | input | 1 | Low to stretch the command |
| iorN | output | 1 | I/O read strobe, active low |
| iowN | output | 1 | I/O write strobe, active low |
| memrN | output | 1 | Memory read strobe, active low |
| memwN | output | 1 | Memory write strobe, active low |
| done | output | 1 | One-cycle end-of-cycle pulse |

## Verification
Two events can land in the same cycle. The first is a configuration write arriving together with `start`; the transfer started in that cycle must run with the old settings, and the next one with the new settings. The bench provokes this by raising `cfgWe` and `start` at the same edge, with a new value whose low time differs. It then judges the outcome by counting the bus clocks the write strobe spends low in the current and the following transfer. The second case is a new `start` that coincides with the `done` cycle. That pulse must be dropped, which the bench confirms by observing exactly one `done` and no second strobe-low period.

// File: rtl/dmaStrobePkg.sv
package dmaStrobePkg;
  typedef struct packed {
    logic capture;   // accept a start, latch settings, assert strobes
    logic memrLate;  // first DMA clock of the command
    logic finish;    // release all strobes
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_DONE} xferState_t;
endpackage

// File: rtl/dmaStrobeCtl.sv
module dmaStrobeCtl
  import dmaStrobePkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             readyIn,
  input  logic [CNT_W-1:0] lowLen,
  input  logic             fastClk,
  output ctlStrobe_t       strb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  xferState_t       state;
  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             lastTick;

  // DMA clock enable: every bus clock in fast mode, every second otherwise
  assign tick     = (state == ST_ACTIVE) && (fastClk || phase);
  assign lastTick = tick && (cnt == lowLen - ONE);

  assign strb.capture  = (state == ST_IDLE) && start;
  assign strb.memrLate = tick && (cnt == '0);
  assign strb.finish   = lastTick && readyIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.capture) begin
            state <= ST_ACTIVE;
            phase <= 1'b0;   // divider restarts with the transfer
            cnt   <= '0;
          end
        end
        ST_ACTIVE: begin
          phase <= ~phase;
          if (tick && !lastTick) cnt <= cnt + ONE;
          if (strb.finish) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaStrobeDp.sv
module dmaStrobeDp
  import dmaStrobePkg::*;
#(
  parameter int WAIT_W = 2,
  parameter int CNT_W  = WAIT_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [2*WAIT_W+1:0] cfgIn,
  input  logic                dirToMem,
  input  logic                is16,
  input  ctlStrobe_t          strb,
  output logic [CNT_W-1:0]    lowLen,
  output logic                fastClk,
  output logic                iorN,
  output logic                iowN,
  output logic                memrN,
  output logic                memwN,
  output logic                done
);
  localparam int CFG_W = 2*WAIT_W + 2;
  localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(2);

  logic [CFG_W-1:0]  cfgReg;
  logic [WAIT_W-1:0] waitSel;
  logic              dirQ;

  // field layout: [0] fast clock, [1] memr no-delay, then 8-bit, then 16-bit
  assign waitSel = is16 ? cfgReg[CFG_W-1 -: WAIT_W] : cfgReg[2 +: WAIT_W];

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowLen  <= BASE_LEN;
      fastClk <= 1'b0;
      dirQ    <= 1'b0;
      iorN    <= 1'b1;
      iowN    <= 1'b1;
      memrN   <= 1'b1;
      memwN   <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.capture) begin
        lowLen  <= CNT_W'(waitSel) + BASE_LEN;
        fastClk <= cfgReg[0];
        dirQ    <= dirToMem;
        if (dirToMem) begin
          iorN  <= 1'b0;
          memwN <= 1'b0;
        end else begin
          iowN  <= 1'b0;
          memrN <= ~cfgReg[1];
        end
      end
      if (strb.memrLate && !dirQ) memrN <= 1'b0;
      if (strb.finish) begin
        iorN  <= 1'b1;
        iowN  <= 1'b1;
        memrN <= 1'b1;
        memwN <= 1'b1;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmaStrobeGen.sv
module dmaStrobeGen
  import dmaStrobePkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [2*WAIT_W+1:0] cfgIn,
  input  logic                start,
  input  logic                dirToMem,
  input  logic                is16,
  input  logic                readyIn,
  output logic                iorN,
  output logic                iowN,
  output logic                memrN,
  output logic                memwN,
  output logic                done
);
  localparam int CNT_W = WAIT_W + 1;

  ctlStrobe_t       strb;
  logic [CNT_W-1:0] lowLen;
  logic             fastClk;

  dmaStrobeCtl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .readyIn(readyIn),
    .lowLen(lowLen), .fastClk(fastClk), .strb(strb)
  );

  dmaStrobeDp #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .dirToMem(dirToMem), .is16(is16), .strb(strb),
    .lowLen(lowLen), .fastClk(fastClk),
    .iorN(iorN), .iowN(iowN), .memrN(memrN), .memwN(memwN), .done(done)
  );
endmodule

// File: rtl/dmaStrobeGenChk.sv
module dmaStrobeGenChk (
  input logic clk,
  input logic rstN,
  input logic iorN,
  input logic iowN,
  input logic memrN,
  input logic memwN,
  input logic done
);
  // R2: the two read/write pairs never overlap on the same side
  a_r2_io_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!iorN && !iowN));
  a_r2_mem_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memrN && !memwN));
  // R3: the write command is low for at least two bus clocks
  a_r3_min_low_iow: assert property (@(posedge clk) disable iff (!rstN)
    $fell(iowN) |=> !iowN);
  a_r3_min_low_memw: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memwN) |=> !memwN);
  // R8: release coincides with done, done lasts one clock
  a_r8_rise_with_done: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(iowN) || $rose(memwN)) |-> done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (iorN && iowN && memrN && memwN));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: a start during the done cycle cannot launch strobes
  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (iorN && iowN && memrN && memwN));
endmodule

bind dmaStrobeGen dmaStrobeGenChk u_chk (
  .clk(clk), .rstN(rstN), .iorN(iorN), .iowN(iowN),
  .memrN(memrN), .memwN(memwN), .done(done)
);

// File: tb/dmaStrobeGen_bench.sv
`timescale 1ns/1ps
module dmaStrobeGen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [5:0] cfgIn = '0;
  logic start = 1'b0;
  logic dirToMem = 1'b0;
  logic is16 = 1'b0;
  logic readyIn = 1'b1;
  logic iorN, iowN, memrN, memwN, done;

  int applied = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  dmaStrobeGen u_dmaStrobeGen (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn), .start(start),
    .dirToMem(dirToMem), .is16(is16), .readyIn(readyIn),
    .iorN(iorN), .iowN(iowN), .memrN(memrN), .memwN(memwN), .done(done)
  );

  // {cfg[5:0], dirToMem, is16, write-low bus clocks, read-low bus clocks}
  localparam int NVEC = 9;
  localparam logic [17:0] VECS [NVEC] = '{
    {6'b000000, 1'b1, 1'b0, 5'd4,  5'd4},
    {6'b000000, 1'b0, 1'b0, 5'd4,  5'd2},
    {6'b000011, 1'b0, 1'b0, 5'd2,  5'd2},
    {6'b001101, 1'b0, 1'b0, 5'd5,  5'd4},
    {6'b001100, 1'b0, 1'b0, 5'd10, 5'd8},
    {6'b100100, 1'b1, 1'b1, 5'd8,  5'd8},
    {6'b100100, 1'b1, 1'b0, 5'd6,  5'd6},
    {6'b010011, 1'b0, 1'b1, 5'd3,  5'd3},
    {6'b110001, 1'b0, 1'b1, 5'd5,  5'd4}
  };

  task automatic chk(input string what, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic setCfg(input logic [5:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgIn = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic xfer(input logic d, input logic w, input int relAt,
                      input int restartAt, input logic cfgNow,
                      input logic [5:0] cfgVal,
                      output int wLow, output int rLow, output int doneAt,
                      output int wrong, output int doneCnt);
    wLow = 0; rLow = 0; doneAt = 0; wrong = 0; doneCnt = 0;
    @(negedge clk);
    dirToMem = d;
    is16 = w;
    start = 1'b1;
    readyIn = (relAt == 0);
    cfgWe = cfgNow;
    if (cfgNow) cfgIn = cfgVal;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (!(d ? memwN : iowN)) wLow++;
      if (!(d ? iorN : memrN)) rLow++;
      if (done) begin
        doneCnt++;
        if (doneAt == 0) doneAt = j;
      end
      if (d ? (!iowN || !memrN) : (!iorN || !memwN)) wrong++;
      start = (j == restartAt);
      cfgWe = 1'b0;
      if (j == relAt) readyIn = 1'b1;
    end
    start = 1'b0;
    readyIn = 1'b1;
  endtask

  initial begin
    #4000000;
    applied++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    int wl, rl, da, wr, dc;
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    chk("R1 strobes high after reset", {iorN, iowN, memrN, memwN}, 4'b1111);
    chk("R1 done low after reset", done, 0);
    rstN = 1'b1;
    // R1: default configuration (one wait, slow clock, delayed memory read)
    xfer(1'b0, 1'b1, 0, 0, 1'b0, 6'd0, wl, rl, da, wr, dc);
    chk("R1 default write low", wl, 4);
    chk("R1 default memr low", rl, 2);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int k = 0; k < NVEC; k++) begin
      setCfg(VECS[k][17:12]);
      xfer(VECS[k][11], VECS[k][10], 0, 0, 1'b0, 6'd0, wl, rl, da, wr, dc);
      chk($sformatf("R3 R4 R5 write low vec%0d", k), wl, int'(VECS[k][9:5]));
      chk($sformatf("R6 read low vec%0d", k), rl, int'(VECS[k][4:0]));
      chk($sformatf("R8 done position vec%0d", k), da, int'(VECS[k][9:5]) + 1);
      chk($sformatf("R8 single done vec%0d", k), dc, 1);
      chk($sformatf("R2 unused strobes vec%0d", k), wr, 0);
    end

    // R7: ready held low, slow clock: ends at the fourth DMA clock
    setCfg(6'b000000);
    xfer(1'b1, 1'b0, 8, 0, 1'b0, 6'd0, wl, rl, da, wr, dc);
    chk("R7 slow ready stretch", wl, 8);
    chk("R7 done after stretch", da, 9);
    // R7: fast clock, ready released before edge four
    setCfg(6'b000001);
    xfer(1'b0, 1'b0, 4, 0, 1'b0, 6'd0, wl, rl, da, wr, dc);
    chk("R7 fast ready stretch", wl, 4);

    // R9: restart mid-transfer and in the done cycle
    setCfg(6'b000000);
    xfer(1'b1, 1'b0, 0, 3, 1'b0, 6'd0, wl, rl, da, wr, dc);
    chk("R9 restart while active", wl, 4);
    chk("R9 one done while active", dc, 1);
    xfer(1'b1, 1'b0, 0, 5, 1'b0, 6'd0, wl, rl, da, wr, dc);
    chk("R9 restart in done cycle", wl, 4);
    chk("R9 one done in done cycle", dc, 1);

    // R10: config write together with start
    xfer(1'b1, 1'b0, 0, 0, 1'b1, 6'b001101, wl, rl, da, wr, dc);
    chk("R10 current transfer keeps old", wl, 4);
    xfer(1'b1, 1'b0, 0, 0, 1'b0, 6'd0, wl, rl, da, wr, dc);
    chk("R10 next transfer uses new", wl, 5);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule